// File: doc/BRIEF.md
# Two-Way Transaction Clock-Domain Bridge

This block moves a single read or write transaction from a bus-interface clock domain into a system clock domain. It then carries an acknowledge and a 32-bit response word back to the bus domain. The bus side pulses a request strobe for one bus clock and presents a packed 48-bit command word on that cycle. The bridge turns it into a one-cycle write-enable or read-enable pulse on the system side, along with a 14-bit word address and 32-bit write data.

One system cycle after the enable, the bridge samples the system read data, which suits a registered read port. It returns that word to the bus side with a one-cycle acknowledge. Each direction uses a toggle flag with a held data register. The flag crosses through a chain of synchronizing flops, and an edge detector at the far side creates the done pulse and loads the destination register. Only one transaction may be outstanding at a time: the bus side must wait for the acknowledge before it raises the next request.

Top module: `xdom_txn_bridge`

## Requirements
- R1: While the resets are held, and after they are released with no request, `bus_ack`, `sys_wr_en` and `sys_rd_en` are low, and `sys_addr`, `sys_wdata` and `bus_rdata` read zero.
- R2: The command word is sampled only on the bus cycle where `bus_req` is high, and its content on every other cycle has no effect. Its fields are:
  - bit 47: write flag;
  - bit 46: read flag;
  - bits 45:32: word address;
  - bits 31:16: upper half of the write data;
  - bits 15:0: lower half of the write data.
- R3: A request with the write flag set produces exactly one `sys_wr_en` pulse, one system cycle long. During that cycle `sys_addr` equals the address field and `sys_wdata` equals bits 31:0 of the command.
- R4: A request with the read flag set produces exactly one `sys_rd_en` pulse, one system cycle long. During that cycle `sys_addr` equals the address field.
- R5: `sys_rdata` is sampled at the rising system edge that ends the cycle after the enable cycle. That sampled word is the one returned on `bus_rdata`.
- R6: The write-data field of a request without the write flag never reaches `sys_wdata`; `sys_wdata` keeps the data of the last write.
- R7: Every request produces exactly one `bus_ack` pulse, one bus cycle long. `bus_rdata` takes its new value in that same cycle and holds it until the next acknowledge.
- R8: A request with neither flag set produces no enable pulse and still receives exactly one acknowledge.
- R9: `sys_addr` changes only at the system edge that follows the arrival of a request in the system domain.
- R10: The enable pulse of a request always occurs before its acknowledge appears on the bus side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-interface domain clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_req | input | 1 | One-cycle transaction request strobe |
| bus_cmd | input | 48 | Packed command word (flags, address, write data) |
| bus_ack | output | 1 | One-cycle acknowledge strobe |
| bus_rdata | output | 32 | Returned response word |
| sys_clk | input | 1 | System domain clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| sys_addr | output | 14 | Word address toward the register file |
| sys_wr_en | output | 1 | One-cycle write enable |
| sys_rd_en | output | 1 | One-cycle read enable |
| sys_wdata | output | 32 | Write data toward the register file |
| sys_rdata | input | 32 | Read data from a registered read port |

## Verification
The forward path is due as follows. The bus-side flag toggles at the bus edge that samples `bus_req`. The flag then needs two synchronizer edges, an edge-detect edge and an output-register edge in the system domain, so the enable appears at most five system edges later. The returned word is latched two system edges after the enable-register edge. It then takes the same four-flop route back, so `bus_ack` and the new `bus_rdata` appear together roughly four bus edges after that.

Because the two clocks are unrelated, the bench does not wait a fixed cycle count. It samples `bus_ack` on falling bus edges and times out after a bounded number of cycles. Enables and acknowledges are counted on rising edges, so extra or missing pulses show up a few cycles after each acknowledge.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int CMD_W  = 2 + ADDR_W + DATA_W;

  // Field order is decoded by the bus-side neighbour: keep it.
  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [HALF_W-1:0] wd_hi;
    logic [HALF_W-1:0] wd_lo;
  } cmd_t;
endpackage

// File: rtl/xdb_toggle_xfer.sv
module xdb_toggle_xfer #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         src_go,
  input  logic [W-1:0] src_word,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic         dst_pulse,
  output logic [W-1:0] dst_word
);
  localparam int LAST = SYNC_STAGES - 1;

  // Source side: flip the flag and freeze the word together.
  logic         src_flag;
  logic [W-1:0] src_hold;

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      src_flag <= 1'b0;
      src_hold <= '0;
    end else if (src_go) begin
      src_flag <= ~src_flag;
      src_hold <= src_word;
    end
  end

  // Destination side: synchronizer chain plus one delay flop for edge detect.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_q;
  logic                   flip;

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      sync_q <= '0;
      edge_q <= 1'b0;
    end else begin
      sync_q[0] <= src_flag;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      edge_q <= sync_q[LAST];
    end
  end

  assign flip = sync_q[LAST] ^ edge_q;

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      dst_pulse <= 1'b0;
      dst_word  <= '0;
    end else begin
      dst_pulse <= flip;
      if (flip) dst_word <= src_hold;
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_pulse |=> !dst_pulse);

  // R7
  word_hold_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    !dst_pulse |-> $stable(dst_word));
endmodule

// File: rtl/xdb_sys_engine.sv
module xdb_sys_engine
  import xdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_pulse,
  input  cmd_t              req_cmd,
  input  logic [DATA_W-1:0] rdata,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              ret_go,
  output logic [DATA_W-1:0] ret_word
);
  // Stage tracking: hold_q marks the enable cycle, fetch_q the sampling cycle.
  logic hold_q;
  logic fetch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      rd_en   <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      hold_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      wr_en   <= req_pulse & req_cmd.wr;
      rd_en   <= req_pulse & req_cmd.rd;
      hold_q  <= req_pulse;
      fetch_q <= hold_q;
      if (req_pulse) addr <= req_cmd.addr;
      if (req_pulse && req_cmd.wr) wdata <= {req_cmd.wd_hi, req_cmd.wd_lo};
    end
  end

  assign ret_go   = fetch_q;
  assign ret_word = rdata;

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_pulse |=> $stable(addr));

  // R6
  wdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (req_pulse && !req_cmd.wr) |=> $stable(wdata));

  // R5
  ret_sched_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |=> ret_go);
endmodule

// File: rtl/xdom_txn_bridge.sv
module xdom_txn_bridge
  import xdb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_req,
  input  logic [CMD_W-1:0]  bus_cmd,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_clk,
  input  logic              sys_rst,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              sys_wr_en,
  output logic              sys_rd_en,
  output logic [DATA_W-1:0] sys_wdata,
  input  logic [DATA_W-1:0] sys_rdata
);
  logic              fwd_pulse;
  logic [CMD_W-1:0]  fwd_word;
  cmd_t              fwd_cmd;
  logic              ret_go;
  logic [DATA_W-1:0] ret_word;

  xdb_toggle_xfer #(.W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) u_fwd (
    .src_clk  (bus_clk),
    .src_rst  (bus_rst),
    .src_go   (bus_req),
    .src_word (bus_cmd),
    .dst_clk  (sys_clk),
    .dst_rst  (sys_rst),
    .dst_pulse(fwd_pulse),
    .dst_word (fwd_word)
  );

  assign fwd_cmd = cmd_t'(fwd_word);

  xdb_sys_engine u_eng (
    .clk      (sys_clk),
    .rst      (sys_rst),
    .req_pulse(fwd_pulse),
    .req_cmd  (fwd_cmd),
    .rdata    (sys_rdata),
    .wr_en    (sys_wr_en),
    .rd_en    (sys_rd_en),
    .addr     (sys_addr),
    .wdata    (sys_wdata),
    .ret_go   (ret_go),
    .ret_word (ret_word)
  );

  xdb_toggle_xfer #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ret (
    .src_clk  (sys_clk),
    .src_rst  (sys_rst),
    .src_go   (ret_go),
    .src_word (ret_word),
    .dst_clk  (bus_clk),
    .dst_rst  (bus_rst),
    .dst_pulse(bus_ack),
    .dst_word (bus_rdata)
  );
endmodule

// File: tb/test_xdom_txn_bridge.sv
module test_xdom_txn_bridge;
  localparam int BUS_PERIOD = 10;
  localparam int SYS_PERIOD = 14;
  localparam int NVEC = 11;

  // {wr, rd, addr[13:0], cmd data[31:0], expected read data[31:0]}
  localparam logic [79:0] VEC [NVEC] = '{
    {2'b10, 14'h0003, 32'hDEADBEEF, 32'h0},
    {2'b10, 14'h3FF5, 32'h12345678, 32'h0},
    {2'b01, 14'h0003, 32'hA5A5A5A5, 32'hDEADBEEF},
    {2'b10, 14'h0000, 32'hFFFFFFFF, 32'h0},
    {2'b01, 14'h3FF5, 32'h5A5A0000, 32'h12345678},
    {2'b01, 14'h0000, 32'h0000C3C3, 32'hFFFFFFFF},
    {2'b10, 14'h2A9C, 32'h00000001, 32'h0},
    {2'b10, 14'h0003, 32'h0BADF00D, 32'h0},
    {2'b01, 14'h0003, 32'h77777777, 32'h0BADF00D},
    {2'b01, 14'h2A9C, 32'h13579BDF, 32'h00000001},
    {2'b01, 14'h0007, 32'hFEEDFACE, 32'h00000000}
  };

  logic        bus_clk = 0, sys_clk = 0;
  logic        bus_rst = 1, sys_rst = 1;
  logic        bus_req = 0;
  logic [47:0] bus_cmd = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [13:0] sys_addr;
  logic        sys_wr_en, sys_rd_en;
  logic [31:0] sys_wdata;
  logic [31:0] sys_rdata;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, ack_cnt = 0;
  logic [13:0] seen_wr_addr = '0, seen_rd_addr = '0;
  logic [31:0] seen_wr_data = '0;
  logic [31:0] exp_wdata = '0;
  logic [31:0] dev_mem [16];

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

  xdom_txn_bridge i_xdom_txn_bridge (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_addr(sys_addr),
    .sys_wr_en(sys_wr_en), .sys_rd_en(sys_rd_en), .sys_wdata(sys_wdata),
    .sys_rdata(sys_rdata)
  );

  // Register-file model with a registered read port.
  always @(posedge sys_clk) begin
    if (sys_rst) begin
      sys_rdata <= '0;
      for (int i = 0; i < 16; i++) dev_mem[i] <= '0;
    end else begin
      if (sys_rd_en) sys_rdata <= dev_mem[sys_addr[3:0]];
      if (sys_wr_en) dev_mem[sys_addr[3:0]] <= sys_wdata;
    end
  end

  // Pulse counters and captures (pre-edge values at the rising edge).
  always @(posedge sys_clk) begin
    if (sys_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      seen_wr_addr <= sys_addr;
      seen_wr_data <= sys_wdata;
    end
    if (sys_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      seen_rd_addr <= sys_addr;
    end
  end

  always @(posedge bus_clk) if (bus_ack) ack_cnt <= ack_cnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic rd, input logic [13:0] a,
                         input logic [31:0] d, input logic [31:0] exp_rd);
    int w0, r0, k0, n;
    w0 = wr_cnt; r0 = rd_cnt; k0 = ack_cnt;
    @(negedge bus_clk);
    bus_req = 1'b1;
    bus_cmd = {wr, rd, a, d};
    @(negedge bus_clk);
    bus_req = 1'b0;
    bus_cmd = {~wr, ~rd, ~a, ~d};   // R2: junk outside the strobe cycle
    n = 0;
    while (!bus_ack && n < 80) begin
      @(negedge bus_clk);
      n++;
    end
    chk(bus_ack == 1'b1, "R7 ack arrives", 64'(bus_ack), 64'd1);
    // R10: enables already counted when the acknowledge is visible
    chk((wr_cnt - w0) == int'(wr) && (rd_cnt - r0) == int'(rd),
        "R10 enable before ack", 64'(wr_cnt - w0), 64'(wr));
    if (rd) chk(bus_rdata == exp_rd, "R5 read data returned", 64'(bus_rdata), 64'(exp_rd));
    repeat (6) @(negedge bus_clk);
    chk(ack_cnt - k0 == 1, "R7 exactly one ack", 64'(ack_cnt - k0), 64'd1);
    chk(wr_cnt - w0 == int'(wr), "R3 write pulse count", 64'(wr_cnt - w0), 64'(wr));
    chk(rd_cnt - r0 == int'(rd), "R4 read pulse count", 64'(rd_cnt - r0), 64'(rd));
    if (rd) begin
      chk(bus_rdata == exp_rd, "R7 rdata held", 64'(bus_rdata), 64'(exp_rd));
      chk(seen_rd_addr == a, "R4 read address", 64'(seen_rd_addr), 64'(a));
    end
    if (wr) begin
      exp_wdata = d;
      chk(seen_wr_addr == a, "R3 write address", 64'(seen_wr_addr), 64'(a));
      chk(seen_wr_data == d, "R2 R3 write data", 64'(seen_wr_data), 64'(d));
    end
    chk(sys_addr == a, "R9 address held", 64'(sys_addr), 64'(a));
    chk(sys_wdata == exp_wdata, "R6 write data kept", 64'(sys_wdata), 64'(exp_wdata));
  endtask

  task automatic reset_both();
    @(negedge bus_clk);
    bus_rst = 1'b1; sys_rst = 1'b1;
    repeat (6) @(negedge bus_clk);
    chk(bus_ack == 0 && sys_wr_en == 0 && sys_rd_en == 0, "R1 strobes low in reset",
        64'({bus_ack, sys_wr_en, sys_rd_en}), 64'd0);
    bus_rst = 1'b0; sys_rst = 1'b0;
    repeat (4) @(negedge bus_clk);
    exp_wdata = '0;
    chk(bus_rdata == 0, "R1 bus_rdata zero", 64'(bus_rdata), 64'd0);
    chk(sys_addr == 0, "R1 sys_addr zero", 64'(sys_addr), 64'd0);
    chk(sys_wdata == 0, "R1 sys_wdata zero", 64'(sys_wdata), 64'd0);
    chk(bus_ack == 0 && sys_wr_en == 0 && sys_rd_en == 0, "R1 strobes low after release",
        64'({bus_ack, sys_wr_en, sys_rd_en}), 64'd0);
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    reset_both();
    for (int v = 0; v < NVEC; v++)
      run_txn(VEC[v][79], VEC[v][78], VEC[v][77:64], VEC[v][63:32], VEC[v][31:0]);
    // R8: neither flag set
    run_txn(1'b0, 1'b0, 14'h1111, 32'hCAFE0000, 32'h0);
    // R6: a read whose data field is all ones must not disturb sys_wdata
    run_txn(1'b0, 1'b1, 14'h2A9C, 32'hFFFFFFFF, 32'h00000001);
    // R1: mid-run reset clears state, then traffic resumes
    reset_both();
    run_txn(1'b1, 1'b0, 14'h3FFF, 32'h80000001, 32'h0);
    run_txn(1'b0, 1'b1, 14'h3FFF, 32'h00000000, 32'h80000001);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule